// File: doc/BRIEF.md
# Reaction Test Sequencer

This block runs a reaction-time test. After reset it sits idle and asks the display for a greeting. A start press captures the present value of a free-running pseudo-random generator as the starting value of a delay counter, so the wait that follows has a different length on each attempt. When the counter reaches its terminal value, the indicator LED lights and the stopwatch is told to run. A stop press freezes the stopwatch and leaves the result on the display until the next reset.

The block only sequences the test. It outputs a two-bit display-mode select, a stopwatch run enable and the LED. The seven-segment driver and the time-counting logic are separate blocks that consume these signals. The terminal count and the counter width are parameters. A full-scale delay of about 15 seconds at a 50 MHz clock is the default, and a bench can use a much shorter delay.

Top module: `reaction_ctrl`

## Requirements
- R1: When `rst` is sampled high at a rising clock edge, after that edge `led_o`=0, `run_o`=0 and `mode_o`=0 (greeting).
- R2: In the idle state, the outputs stay at `led_o`=0, `run_o`=0 and `mode_o`=0 until start is pressed. `stop_btn` has no effect in this state.
- R3: When `start_btn` is sampled high in the idle state, the delay counter loads the low `CNT_W` bits of the generator value present at that edge. After that edge `mode_o`=1, `led_o`=0 and `run_o`=0 (waiting).
- R4: While waiting, the counter increases by one per clock and wraps modulo 2^`CNT_W`. On the edge where it equals `TERM`, the state changes to timing. If L is the loaded value, the LED therefore rises ((`TERM`-L) mod 2^`CNT_W`)+1 edges after the start edge.
- R5: In the timing state `led_o`=1, `run_o`=1 and `mode_o`=1. `led_o` and `run_o` rise on the same edge.
- R6: When `stop_btn` is sampled high in the timing state, after that edge `run_o`=0, while `led_o` stays 1 and `mode_o` stays 1 (done).
- R7: In the done state, `start_btn` and `stop_btn` have no effect until reset.
- R8: While waiting, `start_btn` and `stop_btn` have no effect. The LED still rises on the edge given in R4.
- R9: The generator is a 30-bit register that resets to 0xF. On every clock edge out of reset it shifts left by one, and its new bit 0 is the XOR of its bits 29, 5, 3 and 0.
- R10: `mode_o` encodes 0 = greeting, 1 = stopwatch time, and 2 = reserved for an animated pattern. The block only ever drives 0 or 1.
- R11: Reset is synchronous and active high. From any state it returns the block to the R1 outputs after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start press, sampled every edge |
| stop_btn | input | 1 | Stop press, sampled every edge |
| led_o | output | 1 | Indicator LED, high once the delay expires |
| run_o | output | 1 | Stopwatch run enable |
| mode_o | output | 2 | Display mode select |

## Verification
The bound checker watches, on every cycle, the invariants that hold in any state:
- the run enable implies the LED;
- the LED, once lit, stays lit until reset;
- the run enable falls only after a stop or a reset;
- the display mode is always legal;
- leaving idle requires a start press, and returning to idle requires a reset.

The exact length of each delay cannot be seen by a cycle invariant, because it depends on the generator's history since reset. The bench shows it by predicting the generator from its stated polynomial, and it also covers the presses that are ignored while waiting and when done.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TIME = 2'd2,
    ST_DONE = 2'd3
  } rt_state_t;

  localparam logic [1:0] MODE_HI   = 2'd0;
  localparam logic [1:0] MODE_TIME = 2'd1;
  localparam logic [1:0] MODE_ANIM = 2'd2;

endpackage

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
  parameter int          W    = 30,
  parameter logic [W-1:0] TAPS = W'(32'h2000_0029),
  parameter logic [W-1:0] SEED = W'(32'h0000_000F)
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);

  // XOR of the tapped bits becomes the new least significant bit.
  logic fb;
  assign fb = ^(value & TAPS);

  always_ff @(posedge clk) begin
    if (rst) value <= SEED;
    else     value <= {value[W-2:0], fb};
  end

endmodule

// File: rtl/rt_delay_cnt.sv
module rt_delay_cnt #(
  parameter int W    = 30,
  parameter int TERM = 750_000_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         hit
);

  localparam logic [W-1:0] TERM_V = W'(TERM);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt + 1'b1;   // wraps modulo 2^W
  end

  assign hit = (cnt == TERM_V);

endmodule

// File: rtl/rt_seq_fsm.sv
module rt_seq_fsm
  import rt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stop,
  input  logic       hit,
  output logic       load,
  output logic       step,
  output logic       led,
  output logic       run,
  output logic [1:0] mode
);

  rt_state_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    load   = 1'b0;
    step   = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        load   = 1'b1;
        st_nxt = ST_WAIT;
      end
      ST_WAIT: if (hit) st_nxt = ST_TIME;
               else     step   = 1'b1;
      ST_TIME: if (stop) st_nxt = ST_DONE;
      ST_DONE: st_nxt = ST_DONE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  // Outputs are registered from the next state so they switch with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      led  <= 1'b0;
      run  <= 1'b0;
      mode <= MODE_HI;
    end else begin
      st   <= st_nxt;
      led  <= (st_nxt == ST_TIME) || (st_nxt == ST_DONE);
      run  <= (st_nxt == ST_TIME);
      mode <= (st_nxt == ST_IDLE) ? MODE_HI : MODE_TIME;
    end
  end

endmodule

// File: rtl/reaction_ctrl.sv
module reaction_ctrl #(
  parameter int LFSR_W = 30,
  parameter int CNT_W  = 30,
  parameter int TERM   = 750_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_btn,
  input  logic       stop_btn,
  output logic       led_o,
  output logic       run_o,
  output logic [1:0] mode_o
);

  localparam logic [LFSR_W-1:0] POLY = LFSR_W'(32'h2000_0029);
  localparam logic [LFSR_W-1:0] INIT = LFSR_W'(32'h0000_000F);

  logic [LFSR_W-1:0] rnd;
  logic              load, step, hit;

  rt_lfsr #(.W(LFSR_W), .TAPS(POLY), .SEED(INIT)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .value (rnd)
  );

  rt_delay_cnt #(.W(CNT_W), .TERM(TERM)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (rnd[CNT_W-1:0]),
    .step     (step),
    .hit      (hit)
  );

  rt_seq_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .start (start_btn),
    .stop  (stop_btn),
    .hit   (hit),
    .load  (load),
    .step  (step),
    .led   (led_o),
    .run   (run_o),
    .mode  (mode_o)
  );

endmodule

// File: rtl/reaction_ctrl_chk.sv
module reaction_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_btn,
  input logic       stop_btn,
  input logic       led_o,
  input logic       run_o,
  input logic [1:0] mode_o
);

  a_r5_run_implies_led: assert property (@(posedge clk) disable iff (rst)
    run_o |-> led_o);

  a_r6_led_sticky: assert property (@(posedge clk) disable iff (rst)
    led_o |=> led_o);

  a_r6_run_falls_on_stop: assert property (@(posedge clk) disable iff (rst)
    $fell(run_o) |-> ($past(stop_btn) || $past(rst)));

  a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0) || (mode_o == 2'd1));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0) |-> (!led_o && !run_o));

  a_r3_leave_idle_on_start: assert property (@(posedge clk) disable iff (rst)
    (($past(mode_o) == 2'd0) && (mode_o != 2'd0)) |-> $past(start_btn));

  a_r11_idle_only_by_reset: assert property (@(posedge clk) disable iff (rst)
    (($past(mode_o) != 2'd0) && (mode_o == 2'd0)) |-> $past(rst));

endmodule

bind reaction_ctrl reaction_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_btn (start_btn),
  .stop_btn  (stop_btn),
  .led_o     (led_o),
  .run_o     (run_o),
  .mode_o    (mode_o)
);

// File: tb/reaction_ctrl_bench.sv
`timescale 1ns/1ps
module reaction_ctrl_bench;

  localparam int CNT_W = 8;
  localparam int TERM  = 200;
  localparam int MASK  = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_b = 1'b0;
  logic       stop_b = 1'b0;
  logic       led, run;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [29:0] model;   // generator predicted from R9

  typedef struct {
    int         at;
    logic       led;
    logic       run;
    logic [1:0] mode;
    string      req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;   // 125 MHz

  reaction_ctrl #(.CNT_W(CNT_W), .TERM(TERM)) u_reaction_ctrl (
    .clk(clk), .rst(rst), .start_btn(start_b), .stop_btn(stop_b),
    .led_o(led), .run_o(run), .mode_o(mode)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) model <= 30'hF;
    else     model <= {model[28:0], model[29] ^ model[5] ^ model[3] ^ model[0]};
  end

  // Monitor: pops every expectation due in the current cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at < cyc) begin
        fails++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.req, e.at, cyc);
      end else if (led !== e.led || run !== e.run || mode !== e.mode) begin
        fails++;
        $display("FAIL %s: cycle %0d led/run/mode actual %b/%b/%0d expected %b/%b/%0d",
                 e.req, cyc, led, run, mode, e.led, e.run, e.mode);
      end
    end
  end

  task automatic expect_at(int at, logic l, logic r, logic [1:0] m, string req);
    exp_t e;
    e.at = at; e.led = l; e.run = r; e.mode = m; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Press start in idle; optionally predict the LED edge (R3, R4, R5).
  task automatic press_start(input bit follow, output int c0, output int dl);
    c0 = cyc;
    dl = (TERM - int'(model[CNT_W-1:0])) & MASK;
    expect_at(c0 + 1, 1'b0, 1'b0, 2'd1, "R3");
    if (follow) begin
      expect_at(c0 + dl + 1, 1'b0, 1'b0, 2'd1, "R4");
      expect_at(c0 + dl + 2, 1'b1, 1'b1, 2'd1, "R5");
    end
    start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
  endtask

  task automatic do_reset(int hold_idle);
    int r;
    r = cyc;
    rst = 1'b1;
    expect_at(r + 1, 1'b0, 1'b0, 2'd0, "R11");
    for (int i = 2; i < hold_idle + 2; i++) expect_at(r + i, 1'b0, 1'b0, 2'd0, "R2");
    @(negedge clk);
    rst = 1'b0;
    wait_until(r + hold_idle + 1);
  endtask

  initial begin
    int c, d, s, r0;
    repeat (4) @(negedge clk);
    // R1 / R2: leave reset, idle ignores stop
    r0 = cyc;
    rst = 1'b0;
    stop_b = 1'b1;
    expect_at(r0 + 1, 1'b0, 1'b0, 2'd0, "R1");
    for (int i = 2; i <= 5; i++) expect_at(r0 + i, 1'b0, 1'b0, 2'd0, "R2");
    wait_until(r0 + 5);
    stop_b = 1'b0;

    // Run 1: full sequence with presses ignored while waiting (R8)
    press_start(1'b1, c, d);
    start_b = 1'b1; stop_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0; stop_b = 1'b0;
    for (int i = 3; i <= 5; i++) expect_at(c + d + i, 1'b1, 1'b1, 2'd1, "R8");
    wait_until(c + d + 5);
    s = cyc;
    stop_b = 1'b1;
    expect_at(s + 1, 1'b1, 1'b0, 2'd1, "R6");
    for (int i = 2; i <= 7; i++) expect_at(s + i, 1'b1, 1'b0, 2'd1, "R7");
    @(negedge clk);
    stop_b = 1'b0; start_b = 1'b1;         // R7: start in done ignored
    repeat (2) @(negedge clk);
    stop_b = 1'b1;                          // R7: stop in done ignored
    wait_until(s + 7);
    start_b = 1'b0; stop_b = 1'b0;
    do_reset(3);

    // Run 2: different start time, reset while timing
    repeat (7) @(negedge clk);
    press_start(1'b1, c, d);
    wait_until(c + d + 3);
    do_reset(2);

    // Run 3: reset while waiting
    repeat (3) @(negedge clk);
    press_start(1'b0, c, d);
    do_reset(3);

    // Run 4: another delay pattern to completion
    repeat (11) @(negedge clk);
    press_start(1'b1, c, d);
    wait_until(c + d + 3);
    s = cyc;
    stop_b = 1'b1;
    expect_at(s + 1, 1'b1, 1'b0, 2'd1, "R6");
    @(negedge clk);
    stop_b = 1'b0;
    repeat (3) @(negedge clk);

    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R4: %0d expectations never reached, actual %0d expected 0", q.size(), q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual cycle %0d expected below 20000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule